// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a received bipolar line, presented as a positive-rail bit and a negative-rail bit once per recovered bit clock, and keeps a loss-of-signal flag for the receive path. A bit-valid strobe marks the clock cycles that carry a line bit. A valid bit is a pulse when either rail is high and a zero when both are low. Nothing else about the line symbols is decoded here.

A mode input picks one of two rule sets. The rules for raising the flag and the rules for dropping it are deliberately different. In the slower-rate mode the flag rises after a long run of zeros and drops on a pulse-density test over a sliding 180-bit window. In the faster-rate mode the flag rises after a shorter zero run and drops once a stretch of bits free of four-zero runs has been seen. The flag starts raised after reset and after any change of mode, so a line must prove itself before the flag drops.

Top module: `los_monitor`

## Requirements
- R1: After reset `los` is 1 and all run counters and the pulse history are empty, so 59 pulses alone cannot drop it in mode 0.
- R2: A bit with `bit_vld`=1 is a pulse when `rail_p`=1 or `rail_n`=1 (either rail alone suffices) and a zero when both are 0.
- R3: In mode 0 (`mode_e3`=0) with `los`=0, the 180th consecutive zero sets `los` to 1 at the clock edge that samples that bit; after 179 zeros it is still 0.
- R4: In mode 1 (`mode_e3`=1) with `los`=0, the 32nd consecutive zero sets `los` to 1 at the edge that samples it; after 31 zeros it is still 0.
- R5: In mode 0 with `los`=1, `los` drops to 0 at the edge sampling the bit on which the number of pulses among the last 180 valid bits reaches 60; it can only drop on a pulse.
- R6: In mode 1 with `los`=1, a counter of qualifying bits advances on every valid bit and restarts at zero on any bit whose current zero run is 4 or longer; `los` drops at the edge sampling the bit on which this counter reaches 32.
- R7: Cycles with `bit_vld`=0 change no counter, no history and not `los`, whatever the rails carry.
- R8: A change of `mode_e3` sets `los` to 1 at the next edge, empties all counters and the history, and the bit offered in that cycle is dropped.
- R9: While `los`=0 only the raise rule of the current mode is applied and while `los`=1 only the drop rule; in mode 1 a zero run of 4 to 31 bits leaves `los` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-stage synchronizer |
| bit_vld | input | 1 | High in cycles that carry a line bit |
| rail_p | input | 1 | Positive-rail bit of the current line bit |
| rail_n | input | 1 | Negative-rail bit of the current line bit |
| mode_e3 | input | 1 | Rule set: 0 selects the 180-bit rules, 1 the 32-bit rules |
| los | output | 1 | Loss-of-signal flag, 1 while the line is considered lost |

## Verification
Every counter in this block shows at the ports only as the exact bit on which `los` changes, so a wrong zero-run length, a window count that drifts by one, or a qualifying counter that fails to restart moves an edge of `los` by one bit or more. The bench therefore drives lines whose raise or drop point falls exactly on the boundary bit and compares `los` every cycle against a model, so a fault appears within one bit of the boundary where it matters. A history that is not emptied on a mode change shows up as an early drop within the first 60 pulses after the switch.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    LINE_SLOW = 1'b0,
    LINE_FAST = 1'b1
  } line_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/los_rst_sync.sv
module los_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter  int RUN_SAT  = 180,
  parameter  int ZRUN_LIM = 4,
  parameter  int QUAL_SAT = 32,
  localparam int ZW       = $clog2(RUN_SAT + 1),
  localparam int QW       = $clog2(QUAL_SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          pulse,
  output logic [ZW-1:0] zrun_nxt,
  output logic [QW-1:0] qual_nxt
);

  localparam logic [ZW-1:0] ZSAT_W = ZW'(RUN_SAT);
  localparam logic [ZW-1:0] ZLIM_W = ZW'(ZRUN_LIM);
  localparam logic [QW-1:0] QSAT_W = QW'(QUAL_SAT);

  logic [ZW-1:0] zrun_q;
  logic [ZW-1:0] zrun_d;
  logic [QW-1:0] qual_q;
  logic [QW-1:0] qual_d;

  // zero-run length, saturating at the longest limit in use
  always_comb begin
    zrun_d = zrun_q;
    if (clr) begin
      zrun_d = '0;
    end else if (bit_en) begin
      if (pulse) begin
        zrun_d = '0;
      end else if (zrun_q != ZSAT_W) begin
        zrun_d = zrun_q + 1'b1;
      end
    end
  end

  // qualifying-bit counter: restarts on any bit inside a long zero run
  always_comb begin
    qual_d = qual_q;
    if (clr) begin
      qual_d = '0;
    end else if (bit_en) begin
      if (zrun_d >= ZLIM_W) begin
        qual_d = '0;
      end else if (qual_q != QSAT_W) begin
        qual_d = qual_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q <= '0;
      qual_q <= '0;
    end else begin
      zrun_q <= zrun_d;
      qual_q <= qual_d;
    end
  end

  assign zrun_nxt = zrun_d;
  assign qual_nxt = qual_d;

endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter  int WIN = 180,
  localparam int OW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          pulse,
  output logic [OW-1:0] ones_nxt
);

  logic [WIN-1:0] hist_q;
  logic [WIN-1:0] hist_d;
  logic [OW-1:0]  ones_q;
  logic [OW-1:0]  ones_d;
  logic [OW-1:0]  enter_w;
  logic [OW-1:0]  leave_w;

  assign enter_w = {{(OW-1){1'b0}}, pulse};
  assign leave_w = {{(OW-1){1'b0}}, hist_q[WIN-1]};

  // sliding history and running pulse count over the last WIN bits
  always_comb begin
    hist_d = hist_q;
    ones_d = ones_q;
    if (clr) begin
      hist_d = '0;
      ones_d = '0;
    end else if (bit_en) begin
      hist_d = {hist_q[WIN-2:0], pulse};
      ones_d = ones_q + enter_w - leave_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ones_q <= '0;
    end else begin
      hist_q <= hist_d;
      ones_q <= ones_d;
    end
  end

  assign ones_nxt = ones_d;

endmodule

// File: rtl/los_decide.sv
module los_decide
  import los_pkg::*;
#(
  parameter int SLOW_RUN  = 180,
  parameter int FAST_RUN  = 32,
  parameter int SLOW_MIN  = 60,
  parameter int FAST_QUAL = 32,
  parameter int ZW        = 8,
  parameter int QW        = 6,
  parameter int OW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_chg,
  input  logic          bit_en,
  input  line_mode_e    mode,
  input  logic [ZW-1:0] zrun_nxt,
  input  logic [QW-1:0] qual_nxt,
  input  logic [OW-1:0] ones_nxt,
  output logic          los
);

  localparam logic [ZW-1:0] SLOW_RUN_W  = ZW'(SLOW_RUN);
  localparam logic [ZW-1:0] FAST_RUN_W  = ZW'(FAST_RUN);
  localparam logic [OW-1:0] SLOW_MIN_W  = OW'(SLOW_MIN);
  localparam logic [QW-1:0] FAST_QUAL_W = QW'(FAST_QUAL);

  logic los_q;
  logic los_d;
  logic drop_ok;
  logic raise_ok;

  always_comb begin
    if (mode == LINE_FAST) begin
      drop_ok  = (qual_nxt >= FAST_QUAL_W);
      raise_ok = (zrun_nxt >= FAST_RUN_W);
    end else begin
      drop_ok  = (ones_nxt >= SLOW_MIN_W);
      raise_ok = (zrun_nxt >= SLOW_RUN_W);
    end
  end

  // only the rule that can move the flag away from its state is evaluated
  always_comb begin
    los_d = los_q;
    if (mode_chg) begin
      los_d = 1'b1;
    end else if (bit_en) begin
      if (los_q) begin
        if (drop_ok) los_d = 1'b0;
      end else begin
        if (raise_ok) los_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b1;
    end else begin
      los_q <= los_d;
    end
  end

  assign los = los_q;

endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int SLOW_RUN  = 180,
  parameter int FAST_RUN  = 32,
  parameter int SLOW_WIN  = 180,
  parameter int SLOW_MIN  = 60,
  parameter int FAST_ZLIM = 4,
  parameter int FAST_QUAL = 32,
  parameter int RST_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic rail_p,
  input  logic rail_n,
  input  logic mode_e3,
  output logic los
);

  localparam int RUN_SAT = max_int(SLOW_RUN, FAST_RUN);
  localparam int ZW      = $clog2(RUN_SAT + 1);
  localparam int QW      = $clog2(FAST_QUAL + 1);
  localparam int OW      = $clog2(SLOW_WIN + 1);

  logic          rst_n_i;
  line_mode_e    mode_q;
  line_mode_e    mode_d;
  line_mode_e    mode_in;
  logic          mode_chg;
  logic          bit_en;
  logic          pulse;
  logic [ZW-1:0] zrun_nxt;
  logic [QW-1:0] qual_nxt;
  logic [OW-1:0] ones_nxt;

  los_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign mode_in  = line_mode_e'(mode_e3);
  assign mode_chg = (mode_in != mode_q);
  assign bit_en   = bit_vld & ~mode_chg;
  assign pulse    = rail_p | rail_n;

  always_comb begin
    mode_d = mode_q;
    if (mode_chg) mode_d = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= LINE_SLOW;
    end else begin
      mode_q <= mode_d;
    end
  end

  los_zero_run #(
    .RUN_SAT  (RUN_SAT),
    .ZRUN_LIM (FAST_ZLIM),
    .QUAL_SAT (FAST_QUAL)
  ) u_run (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (mode_chg),
    .bit_en   (bit_en),
    .pulse    (pulse),
    .zrun_nxt (zrun_nxt),
    .qual_nxt (qual_nxt)
  );

  los_density_win #(.WIN(SLOW_WIN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (mode_chg),
    .bit_en   (bit_en),
    .pulse    (pulse),
    .ones_nxt (ones_nxt)
  );

  los_decide #(
    .SLOW_RUN  (SLOW_RUN),
    .FAST_RUN  (FAST_RUN),
    .SLOW_MIN  (SLOW_MIN),
    .FAST_QUAL (FAST_QUAL),
    .ZW        (ZW),
    .QW        (QW),
    .OW        (OW)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .mode_chg (mode_chg),
    .bit_en   (bit_en),
    .mode     (mode_q),
    .zrun_nxt (zrun_nxt),
    .qual_nxt (qual_nxt),
    .ones_nxt (ones_nxt),
    .los      (los)
  );

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic rail_p,
  input logic rail_n,
  input logic mode_e3,
  input logic los
);

  logic los_q;
  logic mode_q;
  logic zero_q;
  logic pulse_q;
  logic vld_q;
  logic chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q   <= 1'b1;
      mode_q  <= 1'b0;
      zero_q  <= 1'b0;
      pulse_q <= 1'b0;
      vld_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      los_q   <= los;
      mode_q  <= mode_e3;
      zero_q  <= bit_vld & ~rail_p & ~rail_n;
      pulse_q <= bit_vld & (rail_p | rail_n);
      vld_q   <= bit_vld;
      chg_q   <= (mode_e3 != mode_q);
    end
  end

  // R3 / R4: the flag rises only on a zero bit or a mode change
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!los_q && los) |-> (zero_q || chg_q));

  // R6: the flag drops only on a valid bit with no mode change
  p_fall_on_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (los_q && !los) |-> (vld_q && !chg_q));

  // R5: in mode 0 the flag drops only on a pulse
  p_slow_fall_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (los_q && !los && !mode_q) |-> pulse_q);

  // R7: an idle cycle leaves the flag unchanged
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_q && !chg_q) |-> (los == los_q));

  // R8: a mode change raises the flag
  p_mode_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> los);

endmodule

bind los_monitor los_monitor_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_vld (bit_vld),
  .rail_p  (rail_p),
  .rail_n  (rail_n),
  .mode_e3 (mode_e3),
  .los     (los)
);

// File: tb/los_monitor_bench.sv
`timescale 1ns/1ps
module los_monitor_bench;

  logic clk;
  logic rst_n;
  logic bit_vld;
  logic rail_p;
  logic rail_n;
  logic mode_e3;
  logic los;

  int n_checks;
  int n_errors;
  bit done;
  string cur_tag;

  // reference state
  bit         m_los;
  bit         m_mode;
  int         m_zrun;
  int         m_qual;
  int         m_ones;
  bit [179:0] m_hist;

  los_monitor u_los_monitor (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .rail_p  (rail_p),
    .rail_n  (rail_n),
    .mode_e3 (mode_e3),
    .los     (los)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void mdl_reset();
    m_los  = 1'b1;
    m_mode = 1'b0;
    m_zrun = 0;
    m_qual = 0;
    m_ones = 0;
    m_hist = '0;
  endfunction

  function automatic void mdl_step(input bit v, input bit p, input bit n, input bit m);
    bit pulse;
    if (m != m_mode) begin
      mdl_reset();
      m_mode = m;
      return;
    end
    if (!v) return;
    pulse  = p | n;
    m_zrun = pulse ? 0 : ((m_zrun < 255) ? m_zrun + 1 : m_zrun);
    m_ones = m_ones + int'(pulse) - int'(m_hist[179]);
    m_hist = {m_hist[178:0], pulse};
    if (m_zrun >= 4) m_qual = 0;
    else if (m_qual < 32) m_qual = m_qual + 1;
    if (m_los) begin
      if (m_mode ? (m_qual >= 32) : (m_ones >= 60)) m_los = 1'b0;
    end else begin
      if (m_zrun >= (m_mode ? 32 : 180)) m_los = 1'b1;
    end
  endfunction

  task automatic check(input logic act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: los=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare the result of the previous bit, then offer the next one
  task automatic step(input bit v, input bit p, input bit n, input bit m);
    @(negedge clk);
    check(los, m_los, cur_tag);
    bit_vld = v; rail_p = p; rail_n = n; mode_e3 = m;
    mdl_step(v, p, n, m);
  endtask

  // directed check against a fixed expected value, then one idle cycle
  task automatic probe(input bit exp, input string tag);
    @(negedge clk);
    check(los, exp, tag);
    bit_vld = 1'b0; rail_p = 1'b1; rail_n = 1'b1;
    mdl_step(1'b0, 1'b1, 1'b1, m_mode);
  endtask

  task automatic pulses(input int cnt, input bit m);
    for (int i = 0; i < cnt; i++) begin
      step(1'b1, i[0], ~i[0], m);
      step(1'b0, 1'b1, 1'b1, m);
    end
  endtask

  task automatic zeros(input int cnt, input bit m);
    for (int i = 0; i < cnt; i++) begin
      step(1'b1, 1'b0, 1'b0, m);
      if (i % 7 == 0) step(1'b0, 1'b1, 1'b0, m);
    end
  endtask

  task automatic pattern_1000(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'b1, (i % 4) == 0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    int dens;
    bit mode_r;
    n_checks = 0; n_errors = 0; done = 1'b0;
    seed = 31337;
    void'($urandom(seed));
    bit_vld = 1'b0; rail_p = 1'b0; rail_n = 1'b0; mode_e3 = 1'b0;
    rst_n = 1'b0;
    mdl_reset();
    repeat (3) @(negedge clk);
    check(los, 1'b1, "R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2 / R5 / R7: mode 0 drop on the 60th pulse, rails used alone
    cur_tag = "R5";
    pulses(59, 1'b0);
    probe(1'b1, "R1 59 pulses after reset");
    pulses(1, 1'b0);
    probe(1'b0, "R2 R5 60th pulse drops flag");

    // R3 / R7: 180 zeros, idle cycles with rails high do not break the run
    cur_tag = "R3";
    zeros(179, 1'b0);
    probe(1'b0, "R3 179 zeros");
    zeros(1, 1'b0);
    probe(1'b1, "R3 180th zero");

    // R5: density 1 in 4 never reaches 60 of 180, 1 in 2 does
    cur_tag = "R5";
    for (int i = 0; i < 400; i++) step(1'b1, (i % 4) == 0, 1'b0, 1'b0);
    probe(1'b1, "R5 sparse line stays lost");
    for (int i = 0; i < 120; i++) step(1'b1, 1'b0, (i % 2) == 0, 1'b0);
    probe(1'b0, "R5 dense line drops flag");

    // R8: mode change raises flag
    cur_tag = "R8";
    step(1'b1, 1'b1, 1'b0, 1'b1);
    probe(1'b1, "R8 change to mode 1");

    // R6: four-zero run restarts the qualifying count
    cur_tag = "R6";
    pattern_1000(20);
    zeros(4, 1'b1);
    pattern_1000(31);
    probe(1'b1, "R6 31 qualifying bits");
    step(1'b1, 1'b0, 1'b0, 1'b1);
    probe(1'b0, "R6 32nd qualifying bit");

    // R9 / R4: zero runs below 32 leave the flag low in mode 1
    cur_tag = "R4";
    step(1'b1, 1'b1, 1'b1, 1'b1);
    zeros(31, 1'b1);
    probe(1'b0, "R9 31 zeros keep flag low");
    zeros(1, 1'b1);
    probe(1'b1, "R4 32nd zero");

    // R8: back to mode 0, history from mode 1 must be gone
    cur_tag = "R8";
    step(1'b1, 1'b0, 1'b0, 1'b0);
    probe(1'b1, "R8 change to mode 0");
    pulses(59, 1'b0);
    probe(1'b1, "R8 history emptied, 59 pulses");
    pulses(1, 1'b0);
    probe(1'b0, "R8 60th pulse after change");

    // random mix compared against the model every cycle
    cur_tag = "R2 random";
    mode_r = 1'b0;
    dens = 50;
    for (int i = 0; i < 6000; i++) begin
      if (i % 200 == 0) begin
        case ($urandom % 5)
          0: dens = 0;
          1: dens = 10;
          2: dens = 34;
          3: dens = 50;
          default: dens = 90;
        endcase
      end
      if (($urandom % 700) == 0) mode_r = ~mode_r;
      step(($urandom % 8) != 0,
           int'($urandom % 100) < dens && ($urandom % 2) == 0,
           int'($urandom % 100) < dens && ($urandom % 2) == 1,
           mode_r);
    end
    step(1'b0, 1'b0, 1'b0, mode_r);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule